// File: doc/BRIEF.md
# HDLC transmit FCS generator

This block sits in an HDLC transmit path between the frame byte source and the stage that does bit stuffing and flag insertion. Frame bytes arrive with a valid/ready handshake and a marker on the final byte. Each byte is passed straight through to the output in the same cycle. The block also folds each byte into a running CRC. When the marked byte has been accepted, the block emits the complemented checksum, low byte first, as extra output beats. It raises a flag request on the final beat so that the next stage closes the frame.

Two configuration inputs pick the checksum. With `cfg_crc32` low the block uses the 16-bit CCITT polynomial and appends two bytes. With it high the block uses the 32-bit polynomial and appends four bytes. With `cfg_ext_fcs` high no checksum is made, because software has already placed the checksum in the frame's last bytes. The frame passes through verbatim and only the flag request is added on its last byte. Both inputs are captured on the first byte of a frame and held until the frame is finished. The block does not judge whether a frame length is sensible.

The controller has three states. `ST_IDLE` waits for the first byte. `ST_BODY` covers the rest of the frame body. `ST_FCS` emits the checksum bytes. The transitions are as follows:
- `ST_IDLE` to `ST_BODY` on a non-final byte.
- `ST_IDLE` or `ST_BODY` to `ST_FCS` on a final byte in generate mode.
- `ST_IDLE` or `ST_BODY` to `ST_IDLE` on a final byte in external mode.
- `ST_FCS` to `ST_IDLE` when the last checksum byte is accepted.

Top module: `hdlc_fcs_tx`

## Requirements
- R1: With `cfg_crc32`=0 and `cfg_ext_fcs`=0, two checksum bytes follow the frame. The CRC uses the reflected CCITT polynomial 0x8408 with an all-ones preset, and the result is inverted. For the ASCII bytes "123456789" the bytes are 0x6E then 0x90.
- R2: With `cfg_crc32`=1, four checksum bytes follow the frame. The CRC uses the reflected polynomial 0xEDB88320 with an all-ones preset, and the result is inverted. For "123456789" the bytes are 0x26, 0x39, 0xF4, 0xCB.
- R3: Checksum bytes leave least significant byte first. Output byte k carries bits [8k+7:8k] of the inverted CRC.
- R4: With `cfg_ext_fcs`=1, the output beats are exactly the input bytes in order. No byte is added.
- R5: `out_flag_req` is high on exactly one accepted beat per frame, the final one. That beat is the last checksum byte, or the last data byte in external mode.
- R6: While checksum bytes are being emitted, `in_ready` is low and `out_valid` is high.
- R7: Both mode inputs are taken on the accepted first byte of a frame. Changes to them later in the same frame have no effect on that frame.
- R8: A frame of a single byte gets a full checksum. No minimum length is enforced.
- R9: Outside checksum emission, `out_data`/`out_valid` follow `in_data`/`in_valid` and `in_ready` follows `out_ready`. A checksum byte held by low `out_ready` stays unchanged until it is accepted.
- R10: During and right after reset, `out_valid` is low and the block is idle, so `in_ready` equals `out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_crc32 | input | 1 | 1 selects the 32-bit checksum, 0 the 16-bit one |
| cfg_ext_fcs | input | 1 | 1 means the checksum is supplied inside the frame |
| in_data | input | 8 | Frame byte from the source |
| in_valid | input | 1 | Source byte valid |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block accepts the source byte |
| out_data | output | 8 | Byte to the stuffing stage |
| out_valid | output | 1 | Output byte valid |
| out_flag_req | output | 1 | Final beat of frame: closing flag due after it |
| out_ready | input | 1 | Stuffing stage accepts the byte |

## Verification
The bench checks the two known-answer vectors. A wrong preset, a missing inversion or a swapped byte order in either width would produce different bytes. A frame whose mode inputs flip right after the first byte catches a design that reads the modes live, which would switch width or drop the checksum partway through. Single-byte frames, where the final byte arrives in `ST_IDLE`, catch a missed direct `ST_IDLE` to `ST_FCS` path. An output stall pattern that lands on checksum bytes catches a serializer that advances or changes its byte without a handshake, which would lose or repeat checksum bytes.

// File: rtl/hdlc_fcs_pkg.sv
package hdlc_fcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_FCS
    } fcs_state_e;

    // reflected polynomials and presets, LSB-first bit order on the line
    localparam logic [31:0] POLY_N16  = 32'h0000_8408;
    localparam logic [31:0] POLY_N32  = 32'hEDB8_8320;
    localparam logic [31:0] PRESET_16 = 32'h0000_FFFF;
    localparam logic [31:0] PRESET_32 = 32'hFFFF_FFFF;

endpackage

// File: rtl/hdlc_fcs_crc.sv
module hdlc_fcs_crc
    import hdlc_fcs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              upd,
    input  logic              wide,
    input  logic [DATA_W-1:0] din,
    output logic [CRC_W-1:0]  crc_nxt
);

    localparam logic [CRC_W-1:0] POLY_W   = CRC_W'(POLY_N32);
    localparam logic [CRC_W-1:0] POLY_S   = CRC_W'(POLY_N16);
    localparam logic [CRC_W-1:0] PRE_W    = CRC_W'(PRESET_32);
    localparam logic [CRC_W-1:0] PRE_S    = CRC_W'(PRESET_16);

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] acc;
    logic [CRC_W-1:0] poly;
    logic             fb;

    assign poly = wide ? POLY_W : POLY_S;

    // one byte folded in per accepted beat, first bit on the wire first
    always_comb begin
        acc = restart ? (wide ? PRE_W : PRE_S) : crc_q;
        fb  = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            fb  = acc[0] ^ din[i];
            acc = acc >> 1;
            if (fb) begin
                acc = acc ^ poly;
            end
        end
        crc_nxt = acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else if (upd) begin
            crc_q <= crc_nxt;
        end
    end

endmodule

// File: rtl/hdlc_fcs_ser.sv
module hdlc_fcs_ser #(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CRC_W-1:0]  load_val,
    input  logic              shift,
    input  logic              wide,
    output logic [DATA_W-1:0] byte_o,
    output logic              last_o
);

    localparam int FCS_MAX = CRC_W / DATA_W;
    localparam int FCS_MIN = 16 / DATA_W;
    localparam int CNT_W   = (FCS_MAX > 1) ? $clog2(FCS_MAX) : 1;
    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(FCS_MAX - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(FCS_MIN - 1);

    logic [CRC_W-1:0] sr_q;
    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sr_q  <= ~load_val;
            idx_q <= '0;
        end else if (shift) begin
            sr_q  <= sr_q >> DATA_W;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign byte_o = sr_q[DATA_W-1:0];
    assign last_o = (idx_q == (wide ? LAST_WIDE : LAST_NARROW));

endmodule

// File: rtl/hdlc_fcs_ctrl.sv
module hdlc_fcs_ctrl
    import hdlc_fcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic out_ready,
    input  logic cfg_crc32,
    input  logic cfg_ext_fcs,
    input  logic fcs_last,
    output logic in_ready,
    output logic take,
    output logic first,
    output logic sel_fcs,
    output logic busy,
    output logic mode_wide,
    output logic mode_ext,
    output logic load_fcs,
    output logic shift_fcs
);

    fcs_state_e state_q, state_d;
    logic       wide_q, ext_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wide_q  <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && take) begin
                wide_q <= cfg_crc32;
                ext_q  <= cfg_ext_fcs;
            end
        end
    end

    // outputs
    always_comb begin
        first     = (state_q == ST_IDLE);
        sel_fcs   = (state_q == ST_FCS);
        busy      = (state_q != ST_IDLE);
        mode_wide = first ? cfg_crc32 : wide_q;
        mode_ext  = first ? cfg_ext_fcs : ext_q;
        in_ready  = !sel_fcs && out_ready;
        take      = in_valid && in_ready;
        load_fcs  = take && in_last && !mode_ext;
        shift_fcs = sel_fcs && out_ready;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) begin
                    if (!in_last)     state_d = ST_BODY;
                    else if (!mode_ext) state_d = ST_FCS;
                end
            end
            ST_BODY: begin
                if (take && in_last) begin
                    state_d = mode_ext ? ST_IDLE : ST_FCS;
                end
            end
            ST_FCS: begin
                if (out_ready && fcs_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/hdlc_fcs_tx.sv
module hdlc_fcs_tx #(
    parameter int DATA_W = 8,
    parameter int CRC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_crc32,
    input  logic              cfg_ext_fcs,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              out_flag_req,
    input  logic              out_ready
);

    logic              take, first, sel_fcs, busy;
    logic              mode_wide, mode_ext, load_fcs, shift_fcs;
    logic              fcs_last;
    logic [CRC_W-1:0]  crc_nxt;
    logic [DATA_W-1:0] fcs_byte;

    hdlc_fcs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_last     (in_last),
        .out_ready   (out_ready),
        .cfg_crc32   (cfg_crc32),
        .cfg_ext_fcs (cfg_ext_fcs),
        .fcs_last    (fcs_last),
        .in_ready    (in_ready),
        .take        (take),
        .first       (first),
        .sel_fcs     (sel_fcs),
        .busy        (busy),
        .mode_wide   (mode_wide),
        .mode_ext    (mode_ext),
        .load_fcs    (load_fcs),
        .shift_fcs   (shift_fcs)
    );

    hdlc_fcs_crc #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (first),
        .upd     (take && !mode_ext),
        .wide    (mode_wide),
        .din     (in_data),
        .crc_nxt (crc_nxt)
    );

    hdlc_fcs_ser #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_fcs),
        .load_val (crc_nxt),
        .shift    (shift_fcs),
        .wide     (mode_wide),
        .byte_o   (fcs_byte),
        .last_o   (fcs_last)
    );

    always_comb begin
        if (sel_fcs) begin
            out_data     = fcs_byte;
            out_valid    = 1'b1;
            out_flag_req = fcs_last;
        end else begin
            out_data     = in_data;
            out_valid    = in_valid;
            out_flag_req = in_valid && in_last && mode_ext;
        end
    end

endmodule

// File: rtl/hdlc_fcs_tx_chk.sv
module hdlc_fcs_tx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_flag_req,
    input logic              out_ready,
    input logic              sel_fcs,
    input logic              busy,
    input logic              mode_wide,
    input logic              mode_ext
);

    logic [2:0] beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q <= '0;
        end else if (sel_fcs && out_ready) begin
            beats_q <= out_flag_req ? 3'd0 : beats_q + 3'd1;
        end
    end

    p_fcs_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fcs && out_ready && out_flag_req) |-> (beats_q == (mode_wide ? 3'd3 : 3'd1)));

    p_ready_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fcs |-> (!in_ready && out_valid));

    p_fcs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_fcs && !out_ready) |=> (sel_fcs && $stable(out_data)));

    p_ext_no_fcs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mode_ext) |-> !sel_fcs);

    p_mode_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mode_wide) && $stable(mode_ext)));

    p_close_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_flag_req) |=> !busy);

endmodule

bind hdlc_fcs_tx hdlc_fcs_tx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_ready     (in_ready),
    .out_data     (out_data),
    .out_valid    (out_valid),
    .out_flag_req (out_flag_req),
    .out_ready    (out_ready),
    .sel_fcs      (sel_fcs),
    .busy         (busy),
    .mode_wide    (mode_wide),
    .mode_ext     (mode_ext)
);

// File: tb/hdlc_fcs_tx_test.sv
module hdlc_fcs_tx_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_crc32 = 1'b0;
    logic       cfg_ext_fcs = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_flag_req;
    logic       out_ready = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic stall_en = 1'b0;

    logic [7:0] src [0:15];
    int         src_n;
    logic [7:0] got_d [0:31];
    logic       got_c [0:31];
    logic       got_r [0:31];
    int         got_n = 0;

    hdlc_fcs_tx uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_crc32    (cfg_crc32),
        .cfg_ext_fcs  (cfg_ext_fcs),
        .in_data      (in_data),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .in_ready     (in_ready),
        .out_data     (out_data),
        .out_valid    (out_valid),
        .out_flag_req (out_flag_req),
        .out_ready    (out_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        #1;
        cyc = cyc + 1;
        out_ready = !(stall_en && (cyc % 3 == 0));
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && got_n < 32) begin
            got_d[got_n] = out_data;
            got_c[got_n] = out_flag_req;
            got_r[got_n] = in_ready;
            got_n = got_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_fcs(input bit wide);
        logic [31:0] c;
        c = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        for (int i = 0; i < src_n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (c[0] ^ src[i][b]) c = (c >> 1) ^ (wide ? 32'hEDB8_8320 : 32'h0000_8408);
                else                  c = c >> 1;
            end
        end
        return wide ? ~c : {16'h0, ~c[15:0]};
    endfunction

    task automatic run_frame(input bit wide, input bit ext, input bit flip, input string req);
        int exp_n;
        logic [31:0] fcs;
        logic [7:0] eb;
        exp_n = src_n + (ext ? 0 : (wide ? 4 : 2));
        fcs = ref_fcs(wide);
        got_n = 0;
        @(posedge clk); #2;
        cfg_crc32 = wide;
        cfg_ext_fcs = ext;
        for (int i = 0; i < src_n; i++) begin
            in_valid = 1'b1;
            in_data  = src[i];
            in_last  = (i == src_n - 1);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #2;
            if (i == 0 && flip) begin
                cfg_crc32 = !wide;
                cfg_ext_fcs = 1'b1;
            end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        for (int w = 0; w < 40; w++) begin
            @(negedge clk);
            if (got_n >= exp_n) break;
        end
        repeat (4) @(negedge clk);
        check(got_n == exp_n, req, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            eb = (i < src_n) ? src[i] : 8'(fcs >> (8 * (i - src_n)));
            check(got_d[i] == eb, req, got_d[i], eb);
            check(got_c[i] == (i == exp_n - 1), "R5", got_c[i], (i == exp_n - 1));
            if (i >= src_n) check(got_r[i] == 1'b0, "R6", got_r[i], 0);
        end
        cfg_crc32 = 1'b0;
        cfg_ext_fcs = 1'b0;
    endtask

    task automatic load_digits();
        for (int i = 0; i < 9; i++) src[i] = 8'h31 + 8'(i);
        src_n = 9;
    endtask

    task automatic t_reset_r10();
        @(negedge clk);
        check(out_valid == 1'b0, "R10", out_valid, 0);
        check(in_ready == out_ready, "R10", in_ready, out_ready);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10", out_valid, 0);
        check(in_ready == 1'b1, "R10", in_ready, 1);
    endtask

    task automatic t_ccitt_r1();
        load_digits();
        run_frame(1'b0, 1'b0, 1'b0, "R1");
        check(got_d[9] == 8'h6E, "R1 R3", got_d[9], 8'h6E);
        check(got_d[10] == 8'h90, "R1 R3", got_d[10], 8'h90);
    endtask

    task automatic t_crc32_r2();
        load_digits();
        run_frame(1'b1, 1'b0, 1'b0, "R2");
        check(got_d[9] == 8'h26, "R2 R3", got_d[9], 8'h26);
        check(got_d[10] == 8'h39, "R2 R3", got_d[10], 8'h39);
        check(got_d[11] == 8'hF4, "R2 R3", got_d[11], 8'hF4);
        check(got_d[12] == 8'hCB, "R2 R3", got_d[12], 8'hCB);
    endtask

    task automatic t_ext_r4();
        src[0] = 8'h03; src[1] = 8'hC1; src[2] = 8'h5A; src[3] = 8'hEE;
        src_n = 4;
        run_frame(1'b0, 1'b1, 1'b0, "R4");
        src_n = 2;
        run_frame(1'b1, 1'b1, 1'b0, "R4");
    endtask

    task automatic t_mode_hold_r7();
        src[0] = 8'h11; src[1] = 8'h22; src[2] = 8'h33; src[3] = 8'h44; src[4] = 8'h55;
        src_n = 5;
        run_frame(1'b0, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_single_r8();
        src[0] = 8'hA5;
        src_n = 1;
        run_frame(1'b1, 1'b0, 1'b0, "R8");
        src[0] = 8'h00;
        run_frame(1'b0, 1'b0, 1'b0, "R8");
    endtask

    task automatic t_stall_r9();
        stall_en = 1'b1;
        src[0] = 8'hFE; src[1] = 8'h7E; src[2] = 8'h01; src[3] = 8'h80; src[4] = 8'h99;
        src_n = 5;
        run_frame(1'b1, 1'b0, 1'b0, "R9");
        load_digits();
        run_frame(1'b0, 1'b0, 1'b0, "R9");
        stall_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset_r10();
        t_ccitt_r1();
        t_crc32_r2();
        t_ext_r4();
        t_mode_hold_r7();
        t_single_r8();
        t_stall_r9();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule